// File: doc/BRIEF.md
# Address-Keyed Bit-Serial Timekeeper

This block is the device side of a timekeeper that sits behind a read-only memory socket and has no select line of its own. Each memory access appears as a one-cycle strobe together with two address lines. Address line 0 carries a data bit and address line 2 gives the direction. The block stays silent until a fixed 64-bit key has arrived, one bit per write access. It then opens exactly one 64-access transfer window over eight 8-bit timekeeping registers.

During a read transfer the block drives the current register bit onto data line 0 and tells the socket to suppress the memory output. During a write transfer it collects the bits in a shadow copy. The shadow copy is committed to the registers in one step, and only when the 64th bit has arrived.

Two bits of the day register configure the block. One of them decides whether an external active-low reset pin may abort a key or a transfer. The other freezes the time base. The calendar counting chain is not part of this block. Its effect is represented by a one-second tick input that advances the seconds register.

Top module: `phantom_clock`

## Requirements
- R1: The key is the 64-bit value 64'h5CA33AC55CA33AC5, sent as write accesses (read line low) with bit i of the key on the data line at the i-th access, bit 0 first. A transfer window opens only after all 64 key bits have matched.
- R2: A write access whose data bit differs from the expected key bit sends the recognizer back to key bit 0. A fresh, complete key is then needed.
- R3: A read access while the key is being received restarts key recognition from bit 0. Outside a transfer window the data-line drive output stays low.
- R4: Transfer bit k (k = 0..63) is bit k%8 of register k/8. Registers 0..7 hold sub-seconds, seconds, minutes, hours, day, date, month and year. On a read access inside the window, the drive output is 1 and data line 0 carries that bit.
- R5: Written bits reach the registers only when the 64th transfer access completes. Bits that are read rather than written keep their old value. After the 64th access the block is idle again.
- R6: Register values are stored exactly as written, with no range check. For example, 8'hFF is kept in every register.
- R7: When day-register bit 4 is 0, a low on the reset pin at a clock edge aborts any key or transfer in progress and leaves every register unchanged. When that bit is 1, the reset pin has no effect.
- R8: When day-register bit 5 is 1, the time is frozen. When it is 0, each tick adds 1 to the seconds register, wrapping from 8'hFF to 8'h00.
- R9: After reset all registers are zero except the day register, which is 8'h20 (time frozen, reset pin enabled). The block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| acc_stb | input | 1 | One-cycle strobe per socket access |
| acc_data_bit | input | 1 | Address line 0: write data bit |
| acc_read | input | 1 | Address line 2: 1 = read access, 0 = write access |
| rst_pin_n | input | 1 | External active-low abort pin |
| sec_tick | input | 1 | One-second tick from the time base |
| dq_drive | output | 1 | Block drives data line 0; memory output suppressed |
| dq_out | output | 1 | Value driven on data line 0 |

## Verification
Assertions check the following on every cycle:
- a key hit occurs only while no window is open;
- the drive output never rises outside a window;
- an abort closes the window and keeps the registers intact;
- a commit closes the window;
- a stopped time base holds the registers, and a running one advances the seconds register by exactly one per tick.

Only the bench scenarios can show the rest:
- the key value and its bit order;
- the mapping of transfer bits to registers;
- the recovery after a mismatch or a read during recognition;
- a transfer that mixes reads and writes, which commits only at the 64th access;
- the effect of the reset-pin enable bit.

// File: rtl/phc_pkg.sv
package phc_pkg;
   typedef enum logic [0:0] {
      XF_IDLE = 1'b0,
      XF_OPEN = 1'b1
   } xf_state_t;

   localparam logic [63:0] PHC_KEY_DEFAULT = 64'h5CA3_3AC5_5CA3_3AC5;
endpackage

// File: rtl/phc_pattern_matcher.sv
module phc_pattern_matcher #(
   parameter int              KEY_BITS = 64,
   parameter logic [KEY_BITS-1:0] KEY  = phc_pkg::PHC_KEY_DEFAULT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic is_rd,
   input  logic wr_bit,
   input  logic enable,
   input  logic abort,
   output logic hit
);
   localparam int CW = $clog2(KEY_BITS);
   localparam logic [CW-1:0] LAST = CW'(KEY_BITS - 1);

   logic [CW-1:0] pos_q;
   logic          bit_ok;
   logic          take;

   assign bit_ok = (wr_bit == KEY[pos_q]);
   assign take   = stb && enable && !abort;
   assign hit    = take && !is_rd && bit_ok && (pos_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (abort) begin
         pos_q <= '0;
      end else if (take) begin
         if (is_rd || !bit_ok || (pos_q == LAST))
            pos_q <= '0;
         else
            pos_q <= pos_q + 1'b1;
      end
   end

   AST_READ_RESTARTS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (take && is_rd) |=> (pos_q == '0)) else $error("read did not restart key"); // R3

   AST_MISS_RESTARTS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !is_rd && (wr_bit != KEY[pos_q])) |=> (pos_q == '0)) else $error("mismatch kept position"); // R2
endmodule

// File: rtl/phc_xfer_engine.sv
module phc_xfer_engine #(
   parameter int NBITS = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stb,
   input  logic             is_rd,
   input  logic             wr_bit,
   input  logic             abort,
   input  logic [NBITS-1:0] snap,
   output logic             busy,
   output logic             rd_drive,
   output logic             rd_bit,
   output logic             commit,
   output logic [NBITS-1:0] commit_data
);
   import phc_pkg::*;

   localparam int CW = $clog2(NBITS);
   localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

   xf_state_t        state_q;
   logic [CW-1:0]    idx_q;
   logic [NBITS-1:0] shadow_q;
   logic             dirty_q;
   logic             acc;
   logic             last;
   logic [NBITS-1:0] merged;

   assign busy = (state_q == XF_OPEN);
   assign acc  = stb && busy && !abort;
   assign last = (idx_q == LAST);

   always_comb begin
      merged = shadow_q;
      if (!is_rd) merged[idx_q] = wr_bit;
   end

   assign rd_drive    = acc && is_rd;
   assign rd_bit      = rd_drive && shadow_q[idx_q];
   assign commit      = acc && last && (dirty_q || !is_rd);
   assign commit_data = merged;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= XF_IDLE;
         idx_q    <= '0;
         shadow_q <= '0;
         dirty_q  <= 1'b0;
      end else if (abort) begin
         state_q <= XF_IDLE;
         idx_q   <= '0;
         dirty_q <= 1'b0;
      end else if (start) begin
         state_q  <= XF_OPEN;
         idx_q    <= '0;
         shadow_q <= snap;
         dirty_q  <= 1'b0;
      end else if (acc) begin
         shadow_q <= merged;
         dirty_q  <= dirty_q || !is_rd;
         if (last) begin
            state_q <= XF_IDLE;
            idx_q   <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !busy) else $error("window open after commit"); // R5

   AST_ABORT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy) else $error("window open after abort"); // R7

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy) else $error("start while open"); // R1
endmodule

// File: rtl/phc_regfile.sv
module phc_regfile #(
   parameter int               NREG     = 8,
   parameter int               RBITS    = 8,
   parameter int               DAY_IDX  = 4,
   parameter int               OSC_BIT  = 5,
   parameter int               TICK_IDX = 1,
   parameter logic [RBITS-1:0] DAY_INIT = 8'h20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  commit,
   input  logic [NREG*RBITS-1:0] commit_data,
   output logic [NREG*RBITS-1:0] regs_flat
);
   logic [RBITS-1:0] regs_q [NREG];
   logic             osc_stopped;

   assign osc_stopped = regs_q[DAY_IDX][OSC_BIT];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [RBITS-1:0] INIT = (g == DAY_IDX) ? DAY_INIT : '0;
      if (g == TICK_IDX) begin : g_counting
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs_q[g] <= INIT;
            else if (commit)
               regs_q[g] <= commit_data[g*RBITS +: RBITS];
            else if (tick && !osc_stopped)
               regs_q[g] <= regs_q[g] + 1'b1;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)
               regs_q[g] <= INIT;
            else if (commit)
               regs_q[g] <= commit_data[g*RBITS +: RBITS];
         end
      end
      assign regs_flat[g*RBITS +: RBITS] = regs_q[g];
   end

   AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_stopped && !commit) |=> $stable(regs_flat)) else $error("registers moved while frozen"); // R8

   AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !osc_stopped && !commit) |=>
      (regs_flat[TICK_IDX*RBITS +: RBITS] == $past(regs_flat[TICK_IDX*RBITS +: RBITS]) + 1'b1))
      else $error("tick did not advance seconds"); // R8
endmodule

// File: rtl/phantom_clock.sv
module phantom_clock #(
   parameter int                      NREG      = 8,
   parameter int                      RBITS     = 8,
   parameter int                      KEY_BITS  = 64,
   parameter logic [KEY_BITS-1:0]     KEY       = phc_pkg::PHC_KEY_DEFAULT,
   parameter int                      DAY_IDX   = 4,
   parameter int                      TICK_IDX  = 1,
   parameter int                      RSTEN_BIT = 4,
   parameter int                      OSC_BIT   = 5,
   parameter logic [RBITS-1:0]        DAY_INIT  = 8'h20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic acc_stb,
   input  logic acc_data_bit,
   input  logic acc_read,
   input  logic rst_pin_n,
   input  logic sec_tick,
   output logic dq_drive,
   output logic dq_out
);
   localparam int TOTAL = NREG * RBITS;

   if (DAY_IDX >= NREG || TICK_IDX >= NREG) begin : g_bad_index
      $error("register index out of range");
   end
   if (OSC_BIT >= RBITS || RSTEN_BIT >= RBITS || OSC_BIT == RSTEN_BIT) begin : g_bad_bits
      $error("control bit positions invalid");
   end
   if (TOTAL < 2 || KEY_BITS < 2) begin : g_bad_size
      $error("key and register file need at least two bits");
   end

   logic             hit;
   logic             busy;
   logic             abort;
   logic             commit;
   logic [TOTAL-1:0] commit_data;
   logic [TOTAL-1:0] regs_flat;

   assign abort = !rst_pin_n && !regs_flat[DAY_IDX*RBITS + RSTEN_BIT];

   phc_pattern_matcher #(
      .KEY_BITS (KEY_BITS),
      .KEY      (KEY)
   ) u_match (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (acc_stb),
      .is_rd  (acc_read),
      .wr_bit (acc_data_bit),
      .enable (!busy),
      .abort  (abort),
      .hit    (hit)
   );

   phc_xfer_engine #(
      .NBITS (TOTAL)
   ) u_xfer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (hit),
      .stb         (acc_stb),
      .is_rd       (acc_read),
      .wr_bit      (acc_data_bit),
      .abort       (abort),
      .snap        (regs_flat),
      .busy        (busy),
      .rd_drive    (dq_drive),
      .rd_bit      (dq_out),
      .commit      (commit),
      .commit_data (commit_data)
   );

   phc_regfile #(
      .NREG     (NREG),
      .RBITS    (RBITS),
      .DAY_IDX  (DAY_IDX),
      .OSC_BIT  (OSC_BIT),
      .TICK_IDX (TICK_IDX),
      .DAY_INIT (DAY_INIT)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (sec_tick),
      .commit      (commit),
      .commit_data (commit_data),
      .regs_flat   (regs_flat)
   );

   AST_HIT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> !busy) else $error("key hit inside window"); // R1

   AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !dq_drive) else $error("drive outside window"); // R3

   AST_ABORT_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !sec_tick) |=> (regs_flat == $past(regs_flat))) else $error("abort changed registers"); // R7
endmodule

// File: tb/tb_phantom_clock.sv
module tb_phantom_clock;
   localparam logic [63:0] KEY = 64'h5CA3_3AC5_5CA3_3AC5;
   localparam int NV = 5;
   // {stimulus written, expected readback}
   localparam logic [127:0] VEC [NV] = '{
      {64'h9912_3105_2359_5890, 64'h9912_3105_2359_5890},
      {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
      {64'hAA55_AA55_0F0F_F0F0, 64'hAA55_AA55_0F0F_F0F0},
      {64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001},
      {64'h2406_1503_1020_3000, 64'h2406_1503_1020_3000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_stb = 1'b0;
   logic acc_data_bit = 1'b0;
   logic acc_read = 1'b0;
   logic rst_pin_n = 1'b1;
   logic sec_tick = 1'b0;
   logic dq_drive;
   logic dq_out;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   phantom_clock dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_stb      (acc_stb),
      .acc_data_bit (acc_data_bit),
      .acc_read     (acc_read),
      .rst_pin_n    (rst_pin_n),
      .sec_tick     (sec_tick),
      .dq_drive     (dq_drive),
      .dq_out       (dq_out)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic acc(input logic rd, input logic b, output logic drv, output logic dq);
      @(negedge clk);
      acc_stb = 1'b1; acc_read = rd; acc_data_bit = b;
      #1;
      drv = dq_drive; dq = dq_out;
      @(posedge clk);
      #1;
      acc_stb = 1'b0;
   endtask

   task automatic pin_pulse();
      @(negedge clk); rst_pin_n = 1'b0;
      @(negedge clk); rst_pin_n = 1'b1;
   endtask

   task automatic tick_pulse();
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
   endtask

   // flip_at: key bit sent inverted; pulse_at: reset pin pulsed before this bit
   task automatic send_key(input int flip_at, input int pulse_at);
      logic d, q;
      for (int i = 0; i < 64; i++) begin
         if (i == pulse_at) pin_pulse();
         acc(1'b0, KEY[i] ^ (i == flip_at), d, q);
      end
   endtask

   task automatic wr64(input logic [63:0] v);
      logic d, q;
      send_key(-1, -1);
      for (int i = 0; i < 64; i++) acc(1'b0, v[i], d, q);
   endtask

   task automatic rd64(output logic [63:0] v, output int drives);
      logic d, q;
      send_key(-1, -1);
      drives = 0; v = '0;
      for (int i = 0; i < 64; i++) begin
         acc(1'b1, 1'b0, d, q);
         v[i] = q;
         if (d) drives++;
      end
   endtask

   task automatic count_reads(input int n, output int drives);
      logic d, q;
      drives = 0;
      for (int i = 0; i < n; i++) begin
         acc(1'b1, 1'b0, d, q);
         if (d) drives++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] got, cur, nv, exp;
      int drv_n;
      logic d, q;

      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9 / R3: idle after reset, no drive on a read access
      acc(1'b1, 1'b0, d, q);
      chk(d == 1'b0, "R3 idle read no drive", {63'd0, d}, 64'd0);
      rd64(got, drv_n);
      chk(got == 64'h0000_0020_0000_0000, "R9 power-up registers", got, 64'h0000_0020_0000_0000);
      chk(drv_n == 64, "R4 drive on every window read", drv_n, 64);

      // R1 R4 R6: table of write-then-read vectors
      for (int v = 0; v < NV; v++) begin
         wr64(VEC[v][127:64]);
         rd64(got, drv_n);
         chk(got == VEC[v][63:0] && drv_n == 64, "R1 R4 R6 table readback", got, VEC[v][63:0]);
      end
      cur = VEC[NV-1][63:0];

      // R5: mixed window, bit 0 read then bits 1..63 written
      nv = 64'h0123_4567_89AB_CDEF;
      send_key(-1, -1);
      acc(1'b1, 1'b0, d, q);
      chk(d && (q == cur[0]), "R5 first bit reads old value", {62'd0, d, q}, {62'd0, 1'b1, cur[0]});
      for (int i = 1; i < 64; i++) acc(1'b0, nv[i], d, q);
      acc(1'b1, 1'b0, d, q);
      chk(d == 1'b0, "R5 idle after 64th access", {63'd0, d}, 64'd0);
      exp = {nv[63:1], cur[0]};
      rd64(got, drv_n);
      chk(got == exp, "R5 commit merges read bit", got, exp);
      cur = exp;

      // R2: mismatch at bit 10, tail still sent
      send_key(10, -1);
      count_reads(64, drv_n);
      chk(drv_n == 0, "R2 mismatched key opens nothing", drv_n, 0);
      rd64(got, drv_n);
      chk(got == cur && drv_n == 64, "R2 fresh key after mismatch", got, cur);

      // R3: read access after 30 key bits
      for (int i = 0; i < 30; i++) acc(1'b0, KEY[i], d, q);
      acc(1'b1, 1'b0, d, q);
      chk(d == 1'b0, "R3 read during key no drive", {63'd0, d}, 64'd0);
      for (int i = 30; i < 64; i++) acc(1'b0, KEY[i], d, q);
      count_reads(1, drv_n);
      chk(drv_n == 0, "R3 key restarted by read", drv_n, 0);

      // R7: day byte 0x67 -> reset pin enabled; abort mid-transfer
      send_key(-1, -1);
      for (int i = 0; i < 20; i++) acc(1'b0, ~cur[i], d, q);
      pin_pulse();
      count_reads(1, drv_n);
      chk(drv_n == 0, "R7 abort closes window", drv_n, 0);
      rd64(got, drv_n);
      chk(got == cur, "R7 abort keeps registers", got, cur);
      send_key(-1, 40);
      count_reads(1, drv_n);
      chk(drv_n == 0, "R7 abort during key", drv_n, 0);

      // R7: set day bit 4 -> pin ignored (day 0x70 keeps time frozen)
      cur[39:32] = 8'h70;
      wr64(cur);
      send_key(-1, 30);
      count_reads(1, drv_n);
      chk(drv_n == 1, "R7 pin ignored when disabled", drv_n, 1);
      for (int i = 1; i < 64; i++) acc(1'b1, 1'b0, d, q);

      // R8: frozen time base
      repeat (3) tick_pulse();
      rd64(got, drv_n);
      chk(got == cur, "R8 frozen ignores ticks", got, cur);

      // R8: running time base, seconds FE + 3 wraps to 01
      cur[39:32] = 8'h50;
      cur[15:8]  = 8'hFE;
      wr64(cur);
      repeat (3) tick_pulse();
      exp = cur; exp[15:8] = 8'h01;
      rd64(got, drv_n);
      chk(got == exp, "R8 ticks advance seconds", got, exp);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule